// File: doc/BRIEF.md
# Three-Counter Triangle Carrier for Complementary PWM

This block produces the triangle carrier for a three-phase complementary PWM stage that inserts dead time. Three 16-bit up/down counters step together on a shared count-enable pulse. The main counter bounces between the dead-time value and the upper limit. The offset counter bounces between zero and the half-cycle value. The auxiliary counter follows the crest and trough intervals so that duty comparison can go on through the dead-time bands. Duty compare, pin waveforms, buffer transfer and interrupts sit outside this block.

Software writes the dead-time, half-cycle and upper-limit values and then sets the run bit. For the main and offset counters to keep the same span, the upper limit must equal the half-cycle value plus the dead-time value. The block does not check this. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level, sampled on the rising clock edge.

Top module: `pwm_tri_carrier`

## Requirements
- R1: A synchronous active-high `rst` clears all three counters to 0, sets all three direction bits to 1 and drives `aux_valid` to 0 on the next clock.
- R2: On any clock where `run` is 0 (and `rst` is 0), the main counter loads `dead_time`, the offset counter loads 0, and both of their direction bits go to 1. The auxiliary counter and its direction hold their values.
- R3: While `run` is 1 and `tick` is 0, all three counters and all three direction bits hold their values.
- R4: On a tick, the main counter steps one in its direction. If it is counting up and equals `upper_limit`, it turns down and steps to `upper_limit`-1. If it is counting down and equals `dead_time`, it turns up and steps to `dead_time`+1.
- R5: On a tick, the offset counter steps one in its direction. If it is counting up and equals `half_cycle`, it turns down. If it is counting down and equals 0, it turns up. It steps in the new direction on that same tick.
- R6: On a tick where the main counter is counting up and equals `half_cycle`, the auxiliary counter turns down. This rule has the highest priority.
- R7: Otherwise, on a tick where the offset counter is counting down and equals `dead_time`, the auxiliary counter turns up.
- R8: Otherwise, the auxiliary counter turns up when it is counting down and equals `half_cycle`, and turns down when it is counting up and equals `dead_time`. With no rule active, it keeps its direction.
- R9: The auxiliary counter steps in the direction chosen on that tick. Stepping up from `upper_limit` gives 0. Stepping down from 0 gives `upper_limit`.
- R10: `aux_valid` is the value of `run` sampled on the previous clock, and 0 after reset.
- R11: Each direction output is 1 for up-counting and 0 for down-counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run bit; 0 reloads the main and offset counters |
| tick | input | 1 | Count-enable prescale pulse |
| dead_time | input | 16 | Dead-time value |
| half_cycle | input | 16 | Carrier half-cycle value |
| upper_limit | input | 16 | Upper limit of the main counter |
| main_cnt | output | 16 | Main counter |
| main_up | output | 1 | Main counter direction (1 = up) |
| offs_cnt | output | 16 | Offset counter |
| offs_up | output | 1 | Offset counter direction (1 = up) |
| aux_cnt | output | 16 | Auxiliary counter |
| aux_up | output | 1 | Auxiliary counter direction (1 = up) |
| aux_valid | output | 1 | Auxiliary counter is usable for duty comparison |

## Verification
Every output comes from a single register stage. A change on `run`, `tick`, `rst` or the limit inputs that is present at a rising edge shows up on the outputs right after that edge, so the latency is one clock. The bench drives inputs on the falling edge and updates its own expected counter state for the coming rising edge. It then compares all seven outputs on the next falling edge, half a period after the registers have settled. Direction reversals and wraps are checked on that same sample, because the new direction and the stepped value appear together.

// File: rtl/pwm_tri_pkg.sv
package pwm_tri_pkg;
  localparam logic DIR_UP = 1'b1;
  localparam logic DIR_DN = 1'b0;

  // Reason the auxiliary counter picks its next direction, highest priority first.
  typedef enum logic [2:0] {
    AEV_NONE,
    AEV_CREST,
    AEV_TROUGH,
    AEV_AUX_HALF,
    AEV_AUX_DEAD
  } aux_event_t;
endpackage

// File: rtl/pwm_tri_bounce.sv
module pwm_tri_bounce #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         up
);
  import pwm_tri_pkg::*;

  logic [W-1:0] cnt_nx;
  logic         up_nx;

  always_comb begin
    cnt_nx = cnt;
    up_nx  = up;
    if (!run) begin
      cnt_nx = load_val;
      up_nx  = DIR_UP;
    end else if (tick) begin
      if (up == DIR_UP) begin
        if (cnt == hi) begin
          up_nx  = DIR_DN;
          cnt_nx = cnt - 1'b1;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end else begin
        if (cnt == lo) begin
          up_nx  = DIR_UP;
          cnt_nx = cnt + 1'b1;
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= DIR_UP;
    end else begin
      cnt <= cnt_nx;
      up  <= up_nx;
    end
  end

  // R3
  bounce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> ($stable(cnt) && $stable(up)));

  // R4 R5
  bounce_top_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && up && cnt == hi) |=> (!up && cnt == $past(hi) - 1'b1));

  // R4 R5
  bounce_low_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !up && cnt == lo) |=> (up && cnt == $past(lo) + 1'b1));

  // R2
  bounce_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (up && cnt == $past(load_val)));
endmodule

// File: rtl/pwm_tri_aux.sv
module pwm_tri_aux #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] main_cnt,
  input  logic         main_up,
  input  logic [W-1:0] offs_cnt,
  input  logic         offs_up,
  input  logic [W-1:0] dead_time,
  input  logic [W-1:0] half_cycle,
  input  logic [W-1:0] upper_limit,
  output logic [W-1:0] aux_cnt,
  output logic         aux_up
);
  import pwm_tri_pkg::*;

  aux_event_t   ev;
  logic         dir_nx;
  logic [W-1:0] cnt_nx;

  always_comb begin
    if (main_up && main_cnt == half_cycle)
      ev = AEV_CREST;
    else if (!offs_up && offs_cnt == dead_time)
      ev = AEV_TROUGH;
    else if (!aux_up && aux_cnt == half_cycle)
      ev = AEV_AUX_HALF;
    else if (aux_up && aux_cnt == dead_time)
      ev = AEV_AUX_DEAD;
    else
      ev = AEV_NONE;
  end

  always_comb begin
    case (ev)
      AEV_CREST:    dir_nx = DIR_DN;
      AEV_TROUGH:   dir_nx = DIR_UP;
      AEV_AUX_HALF: dir_nx = DIR_UP;
      AEV_AUX_DEAD: dir_nx = DIR_DN;
      default:      dir_nx = aux_up;
    endcase
  end

  always_comb begin
    if (dir_nx == DIR_UP)
      cnt_nx = (aux_cnt == upper_limit) ? '0 : aux_cnt + 1'b1;
    else
      cnt_nx = (aux_cnt == '0) ? upper_limit : aux_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_cnt <= '0;
      aux_up  <= DIR_UP;
    end else if (run && tick) begin
      aux_cnt <= cnt_nx;
      aux_up  <= dir_nx;
    end
  end

  // R2
  aux_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> ($stable(aux_cnt) && $stable(aux_up)));

  // R6
  aux_crest_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && main_up && main_cnt == half_cycle) |=> !aux_up);

  // R7
  aux_trough_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !(main_up && main_cnt == half_cycle)
     && !offs_up && offs_cnt == dead_time) |=> aux_up);

  // R9
  aux_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && dir_nx && aux_cnt == upper_limit) |=> (aux_cnt == '0));

  // R9
  aux_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !dir_nx && aux_cnt == '0) |=> (aux_cnt == $past(upper_limit)));
endmodule

// File: rtl/pwm_tri_carrier.sv
module pwm_tri_carrier #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] dead_time,
  input  logic [W-1:0] half_cycle,
  input  logic [W-1:0] upper_limit,
  output logic [W-1:0] main_cnt,
  output logic         main_up,
  output logic [W-1:0] offs_cnt,
  output logic         offs_up,
  output logic [W-1:0] aux_cnt,
  output logic         aux_up,
  output logic         aux_valid
);
  localparam int LANES = 2;

  logic [W-1:0] lane_lo   [LANES];
  logic [W-1:0] lane_hi   [LANES];
  logic [W-1:0] lane_load [LANES];
  logic [W-1:0] lane_cnt  [LANES];
  logic         lane_up   [LANES];

  // Lane 0: main counter, lane 1: offset counter.
  assign lane_lo[0]   = dead_time;
  assign lane_hi[0]   = upper_limit;
  assign lane_load[0] = dead_time;
  assign lane_lo[1]   = '0;
  assign lane_hi[1]   = half_cycle;
  assign lane_load[1] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pwm_tri_bounce #(.W(W)) u_bounce (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .tick     (tick),
      .lo       (lane_lo[g]),
      .hi       (lane_hi[g]),
      .load_val (lane_load[g]),
      .cnt      (lane_cnt[g]),
      .up       (lane_up[g])
    );
  end

  assign main_cnt = lane_cnt[0];
  assign main_up  = lane_up[0];
  assign offs_cnt = lane_cnt[1];
  assign offs_up  = lane_up[1];

  pwm_tri_aux #(.W(W)) u_aux (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .tick        (tick),
    .main_cnt    (lane_cnt[0]),
    .main_up     (lane_up[0]),
    .offs_cnt    (lane_cnt[1]),
    .offs_up     (lane_up[1]),
    .dead_time   (dead_time),
    .half_cycle  (half_cycle),
    .upper_limit (upper_limit),
    .aux_cnt     (aux_cnt),
    .aux_up      (aux_up)
  );

  always_ff @(posedge clk) begin
    if (rst) aux_valid <= 1'b0;
    else     aux_valid <= run;
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> aux_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !aux_valid);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (main_cnt == '0 && offs_cnt == '0 && aux_cnt == '0
             && main_up && offs_up && aux_up && !aux_valid));
endmodule

// File: tb/test_pwm_tri_carrier.sv
module test_pwm_tri_carrier;
  logic        clk = 1'b0;
  logic        rst, run, tick;
  logic [15:0] dead_time, half_cycle, upper_limit;
  logic [15:0] main_cnt, offs_cnt, aux_cnt;
  logic        main_up, offs_up, aux_up, aux_valid;

  int n_total = 0;
  int n_fail  = 0;

  // expected state
  logic [15:0] e_m, e_o, e_a;
  logic        e_mu, e_ou, e_au, e_v;

  always #10 clk = ~clk;

  pwm_tri_carrier i_pwm_tri_carrier (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .dead_time(dead_time), .half_cycle(half_cycle), .upper_limit(upper_limit),
    .main_cnt(main_cnt), .main_up(main_up), .offs_cnt(offs_cnt), .offs_up(offs_up),
    .aux_cnt(aux_cnt), .aux_up(aux_up), .aux_valid(aux_valid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " main_cnt"}, main_cnt, e_m);
    chk({req, " main_up"},  {15'd0, main_up}, {15'd0, e_mu});
    chk({req, " offs_cnt"}, offs_cnt, e_o);
    chk({req, " offs_up"},  {15'd0, offs_up}, {15'd0, e_ou});
    chk({req, " aux_cnt"},  aux_cnt, e_a);
    chk({req, " aux_up"},   {15'd0, aux_up}, {15'd0, e_au});
    chk({req, " aux_valid"}, {15'd0, aux_valid}, {15'd0, e_v});
  endtask

  // Expected next state from the requirement text, one edge at a time.
  task automatic predict(input logic r, input logic t);
    logic [15:0] nm, no, na;
    logic        nmu, nou, nau;
    nm = e_m; nmu = e_mu; no = e_o; nou = e_ou; na = e_a; nau = e_au;
    if (!r) begin
      nm = dead_time; nmu = 1'b1; no = 16'd0; nou = 1'b1;       // R2
    end else if (t) begin
      // R6 R7 R8: direction choice for the auxiliary counter
      if (e_mu && e_m == half_cycle)        nau = 1'b0;
      else if (!e_ou && e_o == dead_time)   nau = 1'b1;
      else if (!e_au && e_a == half_cycle)  nau = 1'b1;
      else if (e_au && e_a == dead_time)    nau = 1'b0;
      // R9
      if (nau) na = (e_a == upper_limit) ? 16'd0 : e_a + 16'd1;
      else     na = (e_a == 16'd0) ? upper_limit : e_a - 16'd1;
      // R4
      if (e_mu && e_m == upper_limit)      nmu = 1'b0;
      else if (!e_mu && e_m == dead_time)  nmu = 1'b1;
      nm = nmu ? e_m + 16'd1 : e_m - 16'd1;
      // R5
      if (e_ou && e_o == half_cycle)       nou = 1'b0;
      else if (!e_ou && e_o == 16'd0)      nou = 1'b1;
      no = nou ? e_o + 16'd1 : e_o - 16'd1;
    end
    e_m = nm; e_mu = nmu; e_o = no; e_ou = nou; e_a = na; e_au = nau;
    e_v = r;                                                     // R10
  endtask

  task automatic step(input logic r, input logic t);
    run = r; tick = t;
    predict(r, t);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [15:0] d, input logic [15:0] h, input logic [15:0] u);
    dead_time = d; half_cycle = h; upper_limit = u;
    rst = 1'b1; run = 1'b0; tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_m = 0; e_o = 0; e_a = 0; e_mu = 1; e_ou = 1; e_au = 1; e_v = 0;
  endtask

  task automatic t_reset;
    do_reset(16'd2, 16'd5, 16'd7);
    chk_all("R1");
  endtask

  task automatic t_idle_load;
    do_reset(16'd3, 16'd6, 16'd9);
    step(1'b0, 1'b1);
    chk("R2 main load", main_cnt, 16'd3);
    chk("R2 offs load", offs_cnt, 16'd0);
    chk("R2 aux hold", aux_cnt, 16'd0);
    chk("R10 idle valid", {15'd0, aux_valid}, 16'd0);
    chk_all("R2");
  endtask

  task automatic t_hold;
    do_reset(16'd2, 16'd5, 16'd7);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0);
      chk_all("R3");
    end
    chk("R3 main held", main_cnt, 16'd4);
    chk("R10 running valid", {15'd0, aux_valid}, 16'd1);
  endtask

  task automatic t_long_run;
    do_reset(16'd2, 16'd5, 16'd7);
    step(1'b0, 1'b0);
    for (int i = 1; i <= 40; i++) begin
      step(1'b1, (i % 7) != 3);
      chk_all("R4 R5 R8 R11");
    end
    do_reset(16'd2, 16'd5, 16'd7);
    step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    chk("R4 peak", main_cnt, 16'd7);
    chk("R5 peak", offs_cnt, 16'd5);
    step(1'b1, 1'b1);
    chk("R4 after peak", main_cnt, 16'd6);
    chk("R11 main down", {15'd0, main_up}, 16'd0);
    chk("R5 after peak", offs_cnt, 16'd4);
  endtask

  task automatic t_up_wrap;
    do_reset(16'd100, 16'd200, 16'd3);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    chk("R9 before wrap", aux_cnt, 16'd3);
    step(1'b1, 1'b1);
    chk("R9 up wrap", aux_cnt, 16'd0);
    chk("R9 still up", {15'd0, aux_up}, 16'd1);
  endtask

  task automatic t_crest;
    do_reset(16'd5, 16'd5, 16'd3);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R6 crest turn", {15'd0, aux_up}, 16'd0);
    chk("R9 down wrap", aux_cnt, 16'd3);
    step(1'b1, 1'b1);
    chk("R6 keeps down", aux_cnt, 16'd2);
  endtask

  task automatic t_trough;
    do_reset(16'd1, 16'd2, 16'd50);
    step(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    chk("R7 trough turn", {15'd0, aux_up}, 16'd1);
    chk("R7 aux value", aux_cnt, 16'd0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk("R8 dead turn", {15'd0, aux_up}, 16'd0);
    chk("R8 aux value", aux_cnt, 16'd0);
    chk_all("R7 R8");
  endtask

  task automatic t_stop;
    do_reset(16'd2, 16'd5, 16'd7);
    step(1'b0, 1'b0);
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R2 stop main", main_cnt, 16'd2);
    chk("R2 stop offs", offs_cnt, 16'd0);
    chk("R10 stop valid", {15'd0, aux_valid}, 16'd0);
    chk_all("R2 R10");
  endtask

  initial begin : watchdog
    #2000000;
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst = 1'b1; run = 1'b0; tick = 1'b0;
    dead_time = 0; half_cycle = 0; upper_limit = 0;
    @(negedge clk);
    t_reset();
    t_idle_load();
    t_hold();
    t_long_run();
    t_up_wrap();
    t_crest();
    t_trough();
    t_stop();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule